// File: doc/BRIEF.md
# On/Off Backpressure Flit Receive Buffer

This block sits at the downstream end of a network link and stores incoming flits in a first-in first-out queue until a local consumer takes them. Rather than returning a credit for every freed slot, it drives one level back to the sender. A high level means the sender may transmit, and a low level means it must pause. The sender only reacts to that level after a link delay. Flits that are already on the wire when the level drops must still find room, and none is ever discarded.

The block keeps a count of free queue entries. The level goes low when the free count falls below a stop threshold. It goes high again only when the free count climbs above a higher resume threshold. The gap between the two thresholds provides hysteresis, so the link does not toggle on every flit.

Both thresholds are parameters. The stop threshold must cover every flit that can still arrive during the link round trip. The resume threshold must be high enough that the queue does not drain empty before new flits start arriving.

Top module: `onoff_rx_buffer`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `out_valid` is 0, and `link_go` is 1, which means the sender may transmit.
- R2: Flits leave on `out_flit` in the order they arrived, with unchanged contents. A flit is removed on a clock edge where `out_valid` and `out_ready` are both 1.
- R3: A flit presented with `in_valid` is always stored and never dropped. A write into a full queue that is not matched by a removal in the same cycle is an error.
- R4: `link_go` falls at the clock edge where the free-entry count first drops below `STOP_LEVEL`. The output is registered alongside the count.
- R5: `link_go` rises at the clock edge where the free-entry count first rises above `GO_LEVEL`. `GO_LEVEL` is greater than `STOP_LEVEL`.
- R6: While the free-entry count lies between `STOP_LEVEL` and `GO_LEVEL` inclusive, `link_go` keeps its previous value.
- R7: `out_valid` is 1 exactly when the queue holds at least one flit.
- R8: A cycle with both a write and a removal leaves the free-entry count unchanged, and therefore also leaves `link_go` unchanged. This holds even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A flit from the link is present this cycle |
| in_flit | input | DATA_W | Incoming flit |
| out_valid | output | 1 | Queue head is available |
| out_ready | input | 1 | Consumer takes the head this cycle |
| out_flit | output | DATA_W | Queue head |
| link_go | output | 1 | 1 allows the sender to transmit, 0 tells it to pause |

## Verification
The hardest state to reach is a queue that is nearly full while flits are still in flight after `link_go` has dropped. The no-overflow margin and the falling edge are only exercised there.

The bench models a sender that sees `link_go` two cycles late and a two-stage link pipeline. It then runs a directed phase with the consumer fully stalled and the sender always transmitting, so the queue fills right up to that margin. A following full-drain phase drives the free count up through the hysteresis band to the rising edge. Random phases with different send and accept rates then cross both thresholds many times, including simultaneous write and removal.

// File: rtl/onoff_pkg.sv
// Package: shared level encoding for the on/off receive buffer.
// Assumes nothing beyond being compiled first.
package onoff_pkg;
    typedef enum logic {
        LINK_PAUSE = 1'b0,
        LINK_GO    = 1'b1
    } link_level_e;
endpackage

// File: rtl/onoff_fifo_store.sv
// Module: circular flit store with read and write pointers plus wrap bits.
// Assumes the caller never writes when full unless it reads in the same cycle.
module onoff_fifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              has_data,
    output logic              is_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              wr_wrap, rd_wrap;

    // Pointer advance with wrap toggle at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wr_wrap <= 1'b0;
            rd_ptr  <= '0;
            rd_wrap <= 1'b0;
        end else begin
            if (wr_en) begin
                if (wr_ptr == LAST) begin
                    wr_ptr  <= '0;
                    wr_wrap <= ~wr_wrap;
                end else begin
                    wr_ptr <= wr_ptr + 1'b1;
                end
            end
            if (rd_en) begin
                if (rd_ptr == LAST) begin
                    rd_ptr  <= '0;
                    rd_wrap <= ~rd_wrap;
                end else begin
                    rd_ptr <= rd_ptr + 1'b1;
                end
            end
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Head read and fill flags from pointer comparison.
    always_comb begin
        rd_data  = mem[rd_ptr];
        has_data = !((wr_ptr == rd_ptr) && (wr_wrap == rd_wrap));
        is_full  = (wr_ptr == rd_ptr) && (wr_wrap != rd_wrap);
    end
endmodule

// File: rtl/onoff_free_counter.sv
// Module: free-entry counter; also exposes the value it will hold next cycle.
// Assumes push and pop are the accepted write and removal strobes.
module onoff_free_counter #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] free_cnt,
    output logic [CW-1:0] free_next
);
    // Next free count from this cycle's strobes.
    always_comb begin
        case ({push, pop})
            2'b10:   free_next = free_cnt - 1'b1;
            2'b01:   free_next = free_cnt + 1'b1;
            default: free_next = free_cnt;
        endcase
    end

    // Count register, full capacity at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) free_cnt <= CW'(DEPTH);
        else        free_cnt <= free_next;
    end
endmodule

// File: rtl/onoff_gate_ctrl.sv
// Module: hysteretic go/pause level driven from the next free count.
// Assumes GO_LEVEL > STOP_LEVEL and free count changes by at most one per cycle.
module onoff_gate_ctrl
    import onoff_pkg::*;
#(
    parameter int CW         = 5,
    parameter int STOP_LEVEL = 8,
    parameter int GO_LEVEL   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] free_next,
    output logic          link_go
);
    localparam logic [CW-1:0] STOP_C = CW'(STOP_LEVEL);
    localparam logic [CW-1:0] GO_C   = CW'(GO_LEVEL);

    link_level_e level_q, level_d;

    // Change level only when the relevant threshold is crossed.
    always_comb begin
        level_d = level_q;
        if (level_q == LINK_GO && free_next < STOP_C)
            level_d = LINK_PAUSE;
        else if (level_q == LINK_PAUSE && free_next > GO_C)
            level_d = LINK_GO;
    end

    // Level register, go at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= LINK_GO;
        else        level_q <= level_d;
    end

    assign link_go = (level_q == LINK_GO);
endmodule

// File: rtl/onoff_rx_buffer.sv
// Module: downstream flit queue that signals backpressure with one go/pause
// level using two thresholds on the free-entry count.
// Assumes the sender honours link_go within the margin STOP_LEVEL covers.
module onoff_rx_buffer #(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 16,
    parameter int STOP_LEVEL = 8,
    parameter int GO_LEVEL   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_flit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_flit,
    output logic              link_go
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop, full;
    logic [CW-1:0] free_cnt, free_next;

    // Accept every presented flit; full is only legal with a same-cycle removal.
    always_comb begin
        pop  = out_valid && out_ready;
        push = in_valid && (!full || pop);
    end

    onoff_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push),
        .wr_data  (in_flit),
        .rd_en    (pop),
        .rd_data  (out_flit),
        .has_data (out_valid),
        .is_full  (full)
    );

    onoff_free_counter #(.DEPTH(DEPTH), .CW(CW)) i_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .free_cnt  (free_cnt),
        .free_next (free_next)
    );

    onoff_gate_ctrl #(.CW(CW), .STOP_LEVEL(STOP_LEVEL), .GO_LEVEL(GO_LEVEL)) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .free_next (free_next),
        .link_go   (link_go)
    );
endmodule

// File: rtl/onoff_rx_checker.sv
// Module: property checker bound to onoff_rx_buffer.
// Assumes free_cnt is the buffer's internal free-entry count.
module onoff_rx_checker #(
    parameter int DEPTH      = 16,
    parameter int STOP_LEVEL = 8,
    parameter int GO_LEVEL   = 11,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic          out_ready,
    input logic          link_go,
    input logic [CW-1:0] free_cnt
);
    localparam logic [CW-1:0] STOP_C = CW'(STOP_LEVEL);
    localparam logic [CW-1:0] GO_C   = CW'(GO_LEVEL);
    localparam logic [CW-1:0] CAP_C  = CW'(DEPTH);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && free_cnt == '0) |-> (out_valid && out_ready));

    a_r4_pause_below: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_go) |-> (free_cnt < STOP_C));

    a_r5_go_above: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_go) |-> (free_cnt > GO_C));

    a_r6_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt >= STOP_C && free_cnt <= GO_C) |-> $stable(link_go));

    a_r7_valid_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (free_cnt != CAP_C));

    a_r8_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_valid && out_ready) |=> $stable(free_cnt));
endmodule

bind onoff_rx_buffer onoff_rx_checker #(
    .DEPTH(DEPTH), .STOP_LEVEL(STOP_LEVEL), .GO_LEVEL(GO_LEVEL), .CW(CW)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .link_go   (link_go),
    .free_cnt  (free_cnt)
);

// File: tb/test_onoff_rx_buffer.sv
`timescale 1ns/1ps
// Bench: sender with delayed view of link_go and a two-stage link, random and
// directed consumer behaviour, checked against a queue and threshold model.
module test_onoff_rx_buffer;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;
    localparam int STOP   = 8;
    localparam int GO     = 11;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [DATA_W-1:0] in_flit;
    logic              out_valid;
    logic              out_ready;
    logic [DATA_W-1:0] out_flit;
    logic              link_go;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int q [64];
    int qh = 0, qt = 0, mcnt = 0;
    int mfree = DEPTH;
    bit mgo = 1'b1;
    bit seen0 = 1'b1, seen1 = 1'b1;
    bit pv0 = 1'b0, pv1 = 1'b0;
    int pd0 = 0, pd1 = 0;
    int seq = 0;

    onoff_rx_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .STOP_LEVEL(STOP), .GO_LEVEL(GO))
    i_onoff_rx_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
        .link_go(link_go)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Count a check and report a failure line.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected level after a free-count update, from R4/R5/R6.
    function automatic bit next_level(input bit cur, input int free_now);
        if (cur && free_now < STOP) return 1'b0;
        if (!cur && free_now > GO)  return 1'b1;
        return cur;
    endfunction

    // One clock: update the model for the edge, compare, then drive next inputs.
    task automatic step(input int p_send, input int p_ready);
        bit pushed, popped, prev_go;
        @(posedge clk); #1;
        pushed = in_valid;
        popped = (mcnt > 0) && out_ready;
        if (pushed && mcnt == DEPTH && !popped)
            check(1'b0, "R3 overflow", mcnt + 1, DEPTH);
        if (popped) begin qh = (qh + 1) % 64; mcnt--; end
        if (pushed && (mcnt < DEPTH)) begin q[qt] = int'(in_flit); qt = (qt + 1) % 64; mcnt++; end
        mfree = DEPTH - mcnt;
        prev_go = mgo;
        mgo = next_level(mgo, mfree);
        if (pushed && popped)
            check(link_go == prev_go, "R8 balanced cycle", int'(link_go), int'(prev_go));
        else if (prev_go && !mgo)
            check(link_go == mgo, "R4 pause edge", int'(link_go), int'(mgo));
        else if (!prev_go && mgo)
            check(link_go == mgo, "R5 go edge", int'(link_go), int'(mgo));
        else
            check(link_go == mgo, "R6 level hold", int'(link_go), int'(mgo));
        check(out_valid == (mcnt > 0), "R7 valid", int'(out_valid), int'(mcnt > 0));
        // Sender view and link pipeline.
        seen1 = seen0;
        seen0 = link_go;
        pv1 = pv0; pd1 = pd0;
        pv0 = seen1 && ($urandom_range(99) < p_send);
        pd0 = seq;
        if (pv0) seq++;
        in_valid  = pv1;
        in_flit   = DATA_W'(pd1);
        out_ready = ($urandom_range(99) < p_ready);
        if (out_valid && out_ready && mcnt > 0)
            check(int'(out_flit) == q[qh], "R2 order", int'(out_flit), q[qh]);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_flit = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: state right after reset.
        check(out_valid == 1'b0, "R1 empty after reset", int'(out_valid), 0);
        check(link_go == 1'b1, "R1 go after reset", int'(link_go), 1);
        for (int i = 0; i < 2000; i++) step(50, 50);
        // Directed: stalled consumer, sender flat out (R3, R4).
        for (int i = 0; i < 80; i++) step(100, 0);
        check(link_go == 1'b0, "R4 paused when filled", int'(link_go), 0);
        // Directed: full drain with no sending (R5, R6).
        for (int i = 0; i < 60; i++) step(0, 100);
        check(link_go == 1'b1, "R5 go after drain", int'(link_go), 1);
        for (int i = 0; i < 2000; i++) step(100, 50);
        for (int i = 0; i < 1500; i++) step(30, 90);
        for (int i = 0; i < 1500; i++) step(90, 70);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule